// File: doc/BRIEF.md
# Dead-Time PWM Pair Generator

This block drives a high-side and a low-side switch from a single PWM channel. A time-base counter is compared against a duty value to form one raw waveform. The raw waveform is then steered to the two pins in one of three pairing modes. In complementary mode the pins are opposite, with a programmable dead time inserted before each pin turns on. In redundant mode both pins carry the same pulse. In push-pull mode the pulse alternates between the pins on successive periods.

Software programs the block through a write strobe, a 3-bit address and a data word. Period, duty, phase and both dead-time values land in shadow registers. By default the shadow values move to the working set together at the end of a period. An immediate-update option lets them apply on the next clock instead. Each pin has its own override enable, and a pair of override levels sets the forced states. Override changes can either wait for the period end or apply at once. While the channel is disabled, both pins sit at the override levels.

A small state machine sequences the channel. `ST_IDLE` holds the counter cleared while the channel is disabled. `ST_SLOT_A` and `ST_SLOT_B` alternate at every period end; push-pull mode uses them to steer the pulse. There are four transitions. Setting the enable bit moves IDLE to SLOT_A. A period end moves SLOT_A to SLOT_B, and SLOT_B back to SLOT_A. Clearing the enable bit returns any state to IDLE.

Top module: `pwm_dt_gen`

## Requirements
- R1: After reset the channel is disabled and both pins are low.
- R2: While control bit 9 (enable) is 0, the high pin shows control bit 7 and the low pin shows control bit 6.
- R3: With immediate update (control bit 2) clear, writes take effect together at the next period end. The writes covered are period (address 0), duty (address 1), phase (address 2), rising dead time (address 3) and alternate dead time (address 4). An edge-aligned period lasts period+1 clocks.
- R4: Control bits 1:0 = 00 selects complementary mode. In each period the high pin is on for duty minus rising dead time. The low pin is on for (period+1-duty) minus alternate dead time. The two pins are never high together.
- R5: Control bits 1:0 = 01 selects redundant mode. Both pins carry the same pulse, which is duty clocks long in each period.
- R6: Control bits 1:0 = 10 selects push-pull mode. The pulse goes to the high pin and the low pin in alternate periods, and each pin carries it once every two periods. Both pins are never high together, and no pin gets pulses in two consecutive periods, even when period is rewritten.
- R7: In redundant and push-pull modes, a duty change from non-zero to zero leaves both pins fully low from the next period on, with no single-clock pulse.
- R8: With control bit 2 set, writes reach the working set on the next clock. A duty write that moves the compare point past the counter flips the pins mid-period. That transition still carries the full dead time before the other pin turns on.
- R9: Control bit 4 forces the high pin and bit 5 forces the low pin, each independently. The forced levels come from control bits 7 (high pin) and 6 (low pin). With control bit 3 clear, an override applies on the second clock edge after the write.
- R10: With control bit 3 set, override changes wait for the next period end.
- R11: Control bit 8 selects center-aligned counting, with a period of 2*period clocks. In this mode a duty below half the alternate dead time is raised to that half.
- R12: In edge-aligned mode the counter restarts at the phase value, so a period lasts period-phase+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 duty, 2 phase, 3 rise dead time, 4 alternate dead time, 5 control) |
| wr_data | input | CW | Register write data |
| pwm_h_o | output | 1 | High-side drive |
| pwm_l_o | output | 1 | Low-side drive |

## Verification
Three latencies apply after a write. A write reaches its shadow register at the clock edge that samples the strobe. It reaches the pins one edge later in immediate mode, and at the next period end otherwise. A change in the raw compare shows on a pin one edge later, delayed further by the dead-time count for that pin. The bench drives on falling edges and samples on falling edges. It counts pin-high cycles over windows that span whole periods, so the results do not depend on where the window starts. For the shadow, immediate-update and dead-time cases, it first anchors on an observed pin edge and then measures run lengths from there.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

    typedef enum logic [1:0] {
        MODE_COMP  = 2'b00,
        MODE_REDUN = 2'b01,
        MODE_PUSH  = 2'b10,
        MODE_RSVD  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SLOT_A = 2'b01,
        ST_SLOT_B = 2'b10
    } gen_state_e;

    // Control word, bit 9 down to bit 0.
    typedef struct packed {
        logic      enable;
        logic      center;
        logic      ovr_lvl_h;
        logic      ovr_lvl_l;
        logic      ovr_en_l;
        logic      ovr_en_h;
        logic      ovr_sync;
        logic      imm;
        out_mode_e mode;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam logic [2:0] A_PER   = 3'd0;
    localparam logic [2:0] A_DUTY  = 3'd1;
    localparam logic [2:0] A_PHASE = 3'd2;
    localparam logic [2:0] A_DTR   = 3'd3;
    localparam logic [2:0] A_DTA   = 3'd4;
    localparam logic [2:0] A_CTL   = 3'd5;

endpackage

// File: rtl/pwm_dt_regs.sv
module pwm_dt_regs
    import pwm_dt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           run,
    input  logic           commit,
    output ctl_t           ctl_o,
    output logic [CW-1:0]  per_o,
    output logic [CW-1:0]  duty_o,
    output logic [CW-1:0]  phase_o,
    output logic [DTW-1:0] dtr_o,
    output logic [DTW-1:0] dta_o
);

    logic [CW-1:0]  per_s, duty_s, phase_s;
    logic [DTW-1:0] dtr_s, dta_s;
    ctl_t           ctl_q;

    // Shadow registers written by software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_s   <= '0;
            duty_s  <= '0;
            phase_s <= '0;
            dtr_s   <= '0;
            dta_s   <= '0;
            ctl_q   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PER:   per_s   <= wr_data;
                A_DUTY:  duty_s  <= wr_data;
                A_PHASE: phase_s <= wr_data;
                A_DTR:   dtr_s   <= wr_data[DTW-1:0];
                A_DTA:   dta_s   <= wr_data[DTW-1:0];
                A_CTL:   ctl_q   <= ctl_t'(wr_data[CTL_W-1:0]);
                default: ;
            endcase
        end
    end

    // Working set: one shared load enable, so all values move together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_o  <= '0;
            duty_o <= '0;
            dtr_o  <= '0;
            dta_o  <= '0;
        end else if (ctl_q.imm || commit || !run) begin
            per_o  <= per_s;
            duty_o <= duty_s;
            dtr_o  <= dtr_s;
            dta_o  <= dta_s;
        end
    end

    // Phase is consumed only at the restart edge, which is the commit edge.
    assign phase_o = phase_s;
    assign ctl_o   = ctl_q;

endmodule

// File: rtl/pwm_dt_timebase.sv
module pwm_dt_timebase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          center,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] phase,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;
    logic          down_q;

    always_comb begin
        if (center) last_o = run && down_q && (cnt_q == '0);
        else        last_o = run && (cnt_q >= per);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (!center) begin
            down_q <= 1'b0;
            cnt_q  <= last_o ? phase : cnt_q + ONE;
        end else if (down_q) begin
            if (cnt_q == '0) begin
                down_q <= 1'b0;
                cnt_q  <= ONE;
            end else begin
                cnt_q  <= cnt_q - ONE;
            end
        end else if (cnt_q >= per) begin
            down_q <= 1'b1;
            cnt_q  <= (cnt_q == '0) ? cnt_q : cnt_q - ONE;
        end else begin
            cnt_q  <= cnt_q + ONE;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_dt_deadtime.sv
module pwm_dt_deadtime #(
    parameter int DTW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           raw,
    input  logic [DTW-1:0] dtr,
    input  logic [DTW-1:0] dta,
    output logic           raw_q_o,
    output logic           hi_o,
    output logic           lo_o
);

    localparam logic [DTW-1:0] ONE = {{(DTW-1){1'b0}}, 1'b1};

    logic           raw_q;
    logic [DTW-1:0] since_q;

    // Clocks since the last raw edge, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= 1'b0;
            since_q <= '0;
        end else if (!run) begin
            raw_q   <= 1'b0;
            since_q <= '0;
        end else begin
            raw_q <= raw;
            if (raw != raw_q)      since_q <= '0;
            else if (since_q != '1) since_q <= since_q + ONE;
        end
    end

    assign raw_q_o = raw_q;
    assign hi_o    = raw_q  && (since_q >= dtr);
    assign lo_o    = !raw_q && (since_q >= dta);

endmodule

// File: rtl/pwm_dt_gen.sv
module pwm_dt_gen
    import pwm_dt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic          pwm_h_o,
    output logic          pwm_l_o
);

    ctl_t           ctl_q;
    logic [CW-1:0]  per_a, duty_a, phase_s, cnt, duty_eff, half_alt;
    logic [DTW-1:0] dtr_a, dta_a;
    logic           last, commit, run, raw, raw_q, comp_h, comp_l;
    logic           gen_h, gen_l;
    logic           ovr_en_h_q, ovr_en_l_q, ovr_lvl_h_q, ovr_lvl_l_q;
    gen_state_e     state_q, state_d;

    assign run    = (state_q != ST_IDLE);
    assign commit = last && run;

    pwm_dt_regs #(.CW(CW), .DTW(DTW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run(run), .commit(commit), .ctl_o(ctl_q),
        .per_o(per_a), .duty_o(duty_a), .phase_o(phase_s),
        .dtr_o(dtr_a), .dta_o(dta_a)
    );

    pwm_dt_timebase #(.CW(CW)) i_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .center(ctl_q.center),
        .per(per_a), .phase(phase_s), .cnt_o(cnt), .last_o(last)
    );

    // Center-aligned clamp: duty never below half the alternate dead time.
    assign half_alt = {{(CW-DTW){1'b0}}, dta_a >> 1};
    assign duty_eff = (ctl_q.center && (duty_a < half_alt)) ? half_alt : duty_a;
    assign raw      = (cnt < duty_eff);

    pwm_dt_deadtime #(.DTW(DTW)) i_dt (
        .clk(clk), .rst_n(rst_n), .run(run), .raw(raw),
        .dtr(dtr_a), .dta(dta_a), .raw_q_o(raw_q),
        .hi_o(comp_h), .lo_o(comp_l)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ctl_q.enable) state_d = ST_SLOT_A;
            ST_SLOT_A: if (last)         state_d = ST_SLOT_B;
            ST_SLOT_B: if (last)         state_d = ST_SLOT_A;
            default:                     state_d = ST_IDLE;
        endcase
        if (!ctl_q.enable) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Override state: follows control each clock, or only at period end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_en_h_q  <= 1'b0;
            ovr_en_l_q  <= 1'b0;
            ovr_lvl_h_q <= 1'b0;
            ovr_lvl_l_q <= 1'b0;
        end else if (!ctl_q.ovr_sync || commit || !run) begin
            ovr_en_h_q  <= ctl_q.ovr_en_h;
            ovr_en_l_q  <= ctl_q.ovr_en_l;
            ovr_lvl_h_q <= ctl_q.ovr_lvl_h;
            ovr_lvl_l_q <= ctl_q.ovr_lvl_l;
        end
    end

    // Outputs.
    always_comb begin
        unique case (ctl_q.mode)
            MODE_REDUN: begin
                gen_h = raw_q;
                gen_l = raw_q;
            end
            MODE_PUSH: begin
                gen_h = raw_q && (state_q == ST_SLOT_A);
                gen_l = raw_q && (state_q == ST_SLOT_B);
            end
            default: begin
                gen_h = comp_h;
                gen_l = comp_l;
            end
        endcase
        if (!run) begin
            pwm_h_o = ctl_q.ovr_lvl_h;
            pwm_l_o = ctl_q.ovr_lvl_l;
        end else begin
            pwm_h_o = ovr_en_h_q ? ovr_lvl_h_q : gen_h;
            pwm_l_o = ovr_en_l_q ? ovr_lvl_l_q : gen_l;
        end
    end

endmodule

// File: rtl/pwm_dt_checker.sv
module pwm_dt_checker
    import pwm_dt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      run,
    input out_mode_e mode,
    input logic      enable,
    input logic      lvl_h,
    input logic      lvl_l,
    input logic      ovr_any,
    input logic      dtr_nz,
    input logic      pwm_h,
    input logic      pwm_l
);

    logic live_comp;
    assign live_comp = run && (mode == MODE_COMP) && !ovr_any;

    assert_disabled_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (pwm_h == lvl_h && pwm_l == lvl_l));

    assert_comp_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_comp |-> !(pwm_h && pwm_l));

    assert_comp_rise_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_comp && $past(live_comp) && dtr_nz && $fell(pwm_l)) |-> !pwm_h);

    assert_redundant_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_REDUN && !ovr_any) |-> (pwm_h == pwm_l));

    assert_pushpull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_PUSH && !ovr_any) |-> !(pwm_h && pwm_l));

endmodule

bind pwm_dt_gen pwm_dt_checker i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(ctl_q.mode),
    .enable(ctl_q.enable), .lvl_h(ctl_q.ovr_lvl_h), .lvl_l(ctl_q.ovr_lvl_l),
    .ovr_any(ovr_en_h_q || ovr_en_l_q), .dtr_nz(dtr_a != '0),
    .pwm_h(pwm_h_o), .pwm_l(pwm_l_o)
);

// File: tb/test_pwm_dt_gen.sv
`timescale 1ns/1ps
module test_pwm_dt_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_h, pwm_l;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    typedef struct {
        string req;
        int    cycles;
        int    exp_h;
        int    exp_l;
    } win_t;

    win_t sb_q[$];
    int   sb_pushed = 0;
    int   sb_done = 0;

    always #4 clk = ~clk;

    pwm_dt_gen i_pwm_dt_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_h_o(pwm_h), .pwm_l_o(pwm_l)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mk_ctl(input bit en, input bit ctr, input bit lh,
                                           input bit ll, input bit enl, input bit enh,
                                           input bit sync, input bit imm, input logic [1:0] md);
        return {6'b0, en, ctr, lh, ll, enl, enh, sync, imm, md};
    endfunction

    // Driver side of the scoreboard.
    task automatic expect_win(input string req, input int cyc, input int eh, input int el);
        win_t it;
        it.req = req; it.cycles = cyc; it.exp_h = eh; it.exp_l = el;
        sb_q.push_back(it);
        sb_pushed++;
        wait (sb_done == sb_pushed);
    endtask

    // Monitor side: count pin-high cycles over the window.
    initial begin
        forever begin
            win_t it;
            int hc, lc;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            hc = 0; lc = 0;
            for (int i = 0; i < it.cycles; i++) begin
                @(negedge clk);
                hc += int'(pwm_h);
                lc += int'(pwm_l);
            end
            chk(hc == it.exp_h, {it.req, " high pin"}, hc, it.exp_h);
            chk(lc == it.exp_l, {it.req, " low pin"}, lc, it.exp_l);
            sb_done++;
        end
    end

    task automatic wait_h(input logic v);
        while (pwm_h !== v) @(negedge clk);
    endtask

    task automatic run_h(input logic v, output int n);
        n = 0;
        while (pwm_h === v) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(pwm_h === 1'b0, "R1 reset high pin", int'(pwm_h), 0);
        chk(pwm_l === 1'b0, "R1 reset low pin", int'(pwm_l), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: disabled, levels from control
        wr(3'd5, mk_ctl(0, 0, 1, 0, 0, 0, 0, 0, 2'b00));
        chk(pwm_h === 1'b1 && pwm_l === 1'b0, "R2 disabled levels",
            {30'd0, pwm_h, pwm_l}, 2);

        // R4: complementary P=19 duty=8 dtr=2 dta=3
        wr(3'd0, 16'd19); wr(3'd1, 16'd8); wr(3'd3, 16'd2); wr(3'd4, 16'd3);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'b00));
        repeat (60) @(negedge clk);
        expect_win("R4 complementary", 60, 18, 27);

        // R3: period and duty rewritten together mid-period
        wr(3'd3, 16'd0); wr(3'd4, 16'd0);
        repeat (45) @(negedge clk);
        wait_h(1'b1); wait_h(1'b0);
        wr(3'd0, 16'd9); wr(3'd1, 16'd4);
        wait_h(1'b1);
        run_h(1'b1, n); chk(n == 4, "R3 first new pulse width", n, 4);
        run_h(1'b0, n); chk(n == 6, "R3 first new gap", n, 6);

        // R5 and R7: redundant, then duty to zero
        wr(3'd0, 16'd19); wr(3'd1, 16'd8);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'b01));
        repeat (45) @(negedge clk);
        expect_win("R5 redundant", 60, 24, 24);
        wait_h(1'b1); wait_h(1'b0);
        wr(3'd1, 16'd0);
        expect_win("R7 redundant zero", 60, 0, 0);

        // R6 and R7: push-pull, then duty to zero
        wr(3'd1, 16'd8);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'b10));
        repeat (45) @(negedge clk);
        expect_win("R6 push-pull", 80, 16, 16);
        wait_h(1'b1); wait_h(1'b0);
        wr(3'd1, 16'd0);
        expect_win("R7 push-pull zero", 60, 0, 0);

        // R8: immediate update, mid-period duty drop keeps dead time
        wr(3'd3, 16'd2); wr(3'd4, 16'd3); wr(3'd1, 16'd16);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 1, 2'b00));
        repeat (45) @(negedge clk);
        wait_h(1'b0); wait_h(1'b1);
        repeat (4) @(negedge clk);
        wr(3'd1, 16'd4);
        wait_h(1'b0);
        n = 0;
        while (pwm_l !== 1'b1) begin @(negedge clk); n++; end
        chk(n == 3, "R8 dead time on immediate transition", n, 3);

        // R9: override the low pin only, immediately
        wr(3'd1, 16'd8);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 1, 0, 0, 0, 2'b00));
        repeat (45) @(negedge clk);
        expect_win("R9 low pin forced low", 60, 18, 0);

        // R12: phase start, dead time zero
        wr(3'd3, 16'd0); wr(3'd4, 16'd0); wr(3'd2, 16'd5);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'b00));
        repeat (45) @(negedge clk);
        expect_win("R12 phase", 45, 9, 36);

        // R11: center-aligned clamp (duty 1, alt dead time 8 -> 4)
        wr(3'd2, 16'd0); wr(3'd1, 16'd1); wr(3'd4, 16'd8);
        wr(3'd5, mk_ctl(1, 1, 0, 0, 0, 0, 0, 0, 2'b00));
        repeat (100) @(negedge clk);
        expect_win("R11 center clamp", 76, 14, 46);

        // R10: synchronized override waits for period end
        wr(3'd4, 16'd0); wr(3'd0, 16'd199);
        wr(3'd5, mk_ctl(1, 0, 0, 0, 0, 0, 0, 0, 2'b00));
        repeat (420) @(negedge clk);
        wait_h(1'b0); wait_h(1'b1);
        wr(3'd5, mk_ctl(1, 0, 1, 0, 1, 1, 1, 0, 2'b00));
        repeat (5) @(negedge clk);
        chk(pwm_h === 1'b0 && pwm_l === 1'b1, "R10 override held before period end",
            {30'd0, pwm_h, pwm_l}, 1);
        repeat (200) @(negedge clk);
        chk(pwm_h === 1'b1 && pwm_l === 1'b0, "R10 override after period end",
            {30'd0, pwm_h, pwm_l}, 2);

        finish_run();
    end

endmodule